// File: doc/BRIEF.md
# Flash command interface controller

This block turns bus write cycles into commands for a multi-bank NOR-style flash. It sits between the host write port and a single program/erase engine. It keeps a read mode for each bank (array, status, signature or query) and a shared status byte. It drives start, suspend and resume pulses to the engine, and an abort level that follows reset. Program, block erase and bank erase each take two writes. The first write arms the command. The second write supplies the target and, for erase, a confirm code.

While the engine is working, each write passes through a filter that depends on what is running. Read-mode commands always get through. Suspend gets through only for program and block erase. After a suspend, resume is accepted. If the suspended operation is an erase, clear-status and a nested program are also accepted. During an erase suspend, a read of the block being erased is steered to status even when its bank is in array mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While rst_n is low, eng_abort is 1. After reset, status reads 80h, every bank is in array mode (code 00) and no engine pulse occurs.
- R2: Writing FFh, 70h, 90h or 98h (in the low byte of wr_data) sets the addressed bank's mode to 00 (array), 01 (status), 10 (signature) or 11 (query). This works in every state except when the controller is waiting for the second write of a command.
- R3: The sequence 40h followed by any write issues one eng_start pulse. The pulse carries eng_op=01 and the second write's address and data, and it puts that bank into status mode. The bank stays in status mode after the operation completes.
- R4: 20h then D0h starts a block erase (eng_op=10, eng_blk_mask one-hot on the block). 80h then D0h starts a bank erase (eng_op=11, eng_blk_mask = the bank's unprotected blocks). The bank comes from wr_addr bit 11 and the block from bits 10:9.
- R5: If the second write of either erase is not D0h, status bits 5 and 4 are set and nothing is started. Both bits stay set until a clear-status (50h) write is accepted.
- R6: A confirmed bank erase on a bank whose blocks are all protected starts nothing and sets no error bit.
- R7: Status bit 7 reads 0 from the start pulse until the engine reports done or paused, and reads 1 otherwise.
- R8: While an operation runs, any write other than a read-mode command or suspend is ignored. This covers setup codes, clear-status and confirm.
- R9: B0h sent to any bank suspends a running program or block erase with one eng_suspend pulse. Once paused, status bit 7 is 1, with bit 6 set for an erase or bit 2 set for a program. During a bank erase, B0h is ignored.
- R10: While suspended, D0h issues one eng_resume pulse and bit 7 returns to 0. During a program suspend, program setup is ignored.
- R11: During an erase suspend, 50h clears bits 5 and 4. A program (40h plus data) also starts, and status bit 7 is 0 while it runs. When it completes, the controller returns to the suspended state.
- R12: rd_mode gives the mode of the bank named by rd_loc. During an erase suspend, if that bank is in array mode and rd_loc names the suspended block, rd_mode is 01 instead.
- R13: Pulling rst_n low during an operation aborts it. After release, the controller is idle with status 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also aborts the engine |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address: bank in top bits, then block, then offset |
| wr_data | input | DATA_W | Write data; command code in the low byte |
| rd_loc | input | log2(NBANK)+log2(NBLK) | Bank and block of the current read |
| blk_prot | input | NBANK*NBLK | Protection bit per block, bank-major |
| eng_done | input | 1 | Engine finished the current operation (pulse) |
| eng_paused | input | 1 | Engine is held after a suspend |
| bank_mode | output | 2*NBANK | Read mode per bank, two bits each |
| rd_mode | output | 2 | Read mode steering for rd_loc |
| status | output | 8 | Status byte |
| eng_start | output | 1 | Start pulse |
| eng_op | output | 2 | Operation: 01 program, 10 block erase, 11 bank erase |
| eng_addr | output | ADDR_W | Latched target address |
| eng_data | output | DATA_W | Latched program data |
| eng_blk_mask | output | NBLK | Blocks of the target bank to operate on |
| eng_suspend | output | 1 | Suspend pulse |
| eng_resume | output | 1 | Resume pulse |
| eng_abort | output | 1 | Abort level, high while reset is low |

## Verification
Random read-mode codes aimed at random banks show whether each bank's mode is held separately and whether rd_mode picks the right bank. Directed sequences send the same disallowed codes (setup, clear, confirm, suspend) while the controller is idle, running, program-suspended, erase-suspended and bank-erasing. Comparing these cases shows whether each state has its own filter. Protection patterns with some blocks and all blocks locked separate the mask path from the silent skip path. The suspended block and a neighbouring block are read in array mode to show that the steering is confined to one block.

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
  parameter int NBANK  = 2,
  parameter int NBLK   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic [$clog2(NBANK)+$clog2(NBLK)-1:0] rd_loc,
  input  logic [NBANK*NBLK-1:0]                 blk_prot,
  input  logic                                  eng_done,
  input  logic                                  eng_paused,
  output logic [2*NBANK-1:0]                    bank_mode,
  output logic [1:0]                            rd_mode,
  output logic [7:0]                            status,
  output logic                                  eng_start,
  output logic [1:0]                            eng_op,
  output logic [ADDR_W-1:0]                     eng_addr,
  output logic [DATA_W-1:0]                     eng_data,
  output logic [NBLK-1:0]                       eng_blk_mask,
  output logic                                  eng_suspend,
  output logic                                  eng_resume,
  output logic                                  eng_abort
);
  localparam int BKW   = $clog2(NBANK);
  localparam int BLW   = $clog2(NBLK);
  localparam int LOC_W = BKW + BLW;

  localparam logic [1:0] M_ARR = 2'd0, M_STAT = 2'd1, M_SIG = 2'd2, M_QRY = 2'd3;
  localparam logic [1:0] OP_PROG = 2'd1, OP_BERS = 2'd2, OP_KERS = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_SETP, S_SETB, S_SETK, S_RUN, S_SUSP, S_NSETP, S_NRUN
  } st_t;

  st_t              st;
  logic [1:0]       op;
  logic [LOC_W-1:0] op_loc;
  logic             susp_req;
  logic             err;
  logic [1:0]       mode_q [NBANK];

  wire [7:0]       cmd   = wr_data[7:0];
  wire [LOC_W-1:0] wloc  = wr_addr[ADDR_W-1 -: LOC_W];
  wire [BKW-1:0]   wbank = wloc[LOC_W-1 -: BKW];
  wire [BLW-1:0]   wblk  = wloc[BLW-1:0];
  wire [BKW-1:0]   rbank = rd_loc[LOC_W-1 -: BKW];
  wire [NBLK-1:0]  wprot = blk_prot[NBLK*wbank +: NBLK];
  wire [NBLK-1:0]  w_oh  = {{(NBLK-1){1'b0}}, 1'b1} << wblk;

  wire is_rd_cmd = (cmd == 8'hFF) || (cmd == 8'h70) || (cmd == 8'h90) || (cmd == 8'h98);
  wire susp_any  = (st == S_SUSP) || (st == S_NSETP) || (st == S_NRUN);
  wire esusp     = susp_any && (op == OP_BERS);
  wire running   = (st == S_RUN) || (st == S_NRUN);

  function automatic logic [1:0] mode_of(input logic [7:0] c);
    case (c)
      8'h70:   return M_STAT;
      8'h90:   return M_SIG;
      8'h98:   return M_QRY;
      default: return M_ARR;
    endcase
  endfunction

  genvar g;
  generate
    for (g = 0; g < NBANK; g++) begin : g_mode
      assign bank_mode[2*g +: 2] = mode_q[g];
    end
  endgenerate

  wire [1:0] rsel = mode_q[rbank];
  assign rd_mode   = (esusp && rsel == M_ARR && rd_loc == op_loc) ? M_STAT : rsel;
  assign status    = {!running, esusp, err, err, 1'b0, (st == S_SUSP) && (op == OP_PROG), 2'b00};
  assign eng_abort = !rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      op           <= 2'd0;
      op_loc       <= '0;
      susp_req     <= 1'b0;
      err          <= 1'b0;
      eng_start    <= 1'b0;
      eng_op       <= 2'd0;
      eng_addr     <= '0;
      eng_data     <= '0;
      eng_blk_mask <= '0;
      eng_suspend  <= 1'b0;
      eng_resume   <= 1'b0;
      for (int i = 0; i < NBANK; i++) mode_q[i] <= M_ARR;
    end else begin
      eng_start   <= 1'b0;
      eng_suspend <= 1'b0;
      eng_resume  <= 1'b0;
      if (wr_en) begin
        case (st)
          S_SETP, S_NSETP: begin
            eng_start    <= 1'b1;
            eng_op       <= OP_PROG;
            eng_addr     <= wr_addr;
            eng_data     <= wr_data;
            eng_blk_mask <= w_oh;
            mode_q[wbank] <= M_STAT;
            if (st == S_SETP) begin
              op     <= OP_PROG;
              op_loc <= wloc;
              st     <= S_RUN;
            end else begin
              st <= S_NRUN;
            end
          end
          S_SETB: begin
            mode_q[wbank] <= M_STAT;
            if (cmd == 8'hD0) begin
              eng_start    <= 1'b1;
              eng_op       <= OP_BERS;
              eng_addr     <= wr_addr;
              eng_blk_mask <= w_oh;
              op           <= OP_BERS;
              op_loc       <= wloc;
              st           <= S_RUN;
            end else begin
              err <= 1'b1;
              st  <= S_IDLE;
            end
          end
          S_SETK: begin
            mode_q[wbank] <= M_STAT;
            if (cmd != 8'hD0) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else if (&wprot) begin
              st <= S_IDLE;
            end else begin
              eng_start    <= 1'b1;
              eng_op       <= OP_KERS;
              eng_addr     <= wr_addr;
              eng_blk_mask <= ~wprot;
              op           <= OP_KERS;
              op_loc       <= wloc;
              st           <= S_RUN;
            end
          end
          default: begin
            if (is_rd_cmd) begin
              mode_q[wbank] <= mode_of(cmd);
            end else begin
              case (st)
                S_IDLE: begin
                  if (cmd == 8'h40) st <= S_SETP;
                  else if (cmd == 8'h20) st <= S_SETB;
                  else if (cmd == 8'h80) st <= S_SETK;
                  else if (cmd == 8'h50) err <= 1'b0;
                end
                S_RUN: begin
                  if (cmd == 8'hB0 && op != OP_KERS && !susp_req && !eng_done) begin
                    eng_suspend <= 1'b1;
                    susp_req    <= 1'b1;
                  end
                end
                S_SUSP: begin
                  if (cmd == 8'hD0) begin
                    eng_resume <= 1'b1;
                    susp_req   <= 1'b0;
                    st         <= S_RUN;
                  end else if (op == OP_BERS && cmd == 8'h50) begin
                    err <= 1'b0;
                  end else if (op == OP_BERS && cmd == 8'h40) begin
                    st <= S_NSETP;
                  end
                end
                default: ;
              endcase
            end
          end
        endcase
      end
      if (st == S_RUN) begin
        if (eng_done) begin
          st       <= S_IDLE;
          susp_req <= 1'b0;
        end else if (susp_req && eng_paused) begin
          st <= S_SUSP;
        end
      end else if (st == S_NRUN && eng_done) begin
        st <= S_SUSP;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       eng_start,
  input logic       eng_suspend,
  input logic       eng_resume,
  input logic       eng_abort
);
  always_comb begin
    a_r1_abort_in_reset: assert (rst_n || eng_abort);
  end

  a_r7_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !status[7]);

  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r8_start_only_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(status[7]));

  a_r5_error_bits_paired: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] == status[4]);

  a_r9_one_suspend_kind: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> !status[2]);

  a_r10_no_suspend_with_resume: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_suspend && eng_resume));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .eng_start(eng_start),
  .eng_suspend(eng_suspend), .eng_resume(eng_resume), .eng_abort(eng_abort)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int LEN = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_loc = '0;
  logic [7:0]  blk_prot = '0;
  logic        eng_done, eng_paused;
  logic [3:0]  bank_mode;
  logic [1:0]  rd_mode, eng_op;
  logic [7:0]  status;
  logic        eng_start, eng_suspend, eng_resume, eng_abort;
  logic [11:0] eng_addr;
  logic [15:0] eng_data;
  logic [3:0]  eng_blk_mask;

  int checks = 0, errors = 0;
  int n_start = 0, n_susp = 0, n_res = 0;
  logic [1:0]  l_op;
  logic [11:0] l_addr;
  logic [15:0] l_data;
  logic [3:0]  l_mask;
  logic [1:0]  bm_exp [2];
  int main_c, nest_c;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_loc(rd_loc), .blk_prot(blk_prot), .eng_done(eng_done), .eng_paused(eng_paused),
    .bank_mode(bank_mode), .rd_mode(rd_mode), .status(status), .eng_start(eng_start),
    .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data), .eng_blk_mask(eng_blk_mask),
    .eng_suspend(eng_suspend), .eng_resume(eng_resume), .eng_abort(eng_abort)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_c <= 0; nest_c <= 0; eng_done <= 1'b0; eng_paused <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) begin
        if (eng_paused) nest_c <= LEN; else main_c <= LEN;
      end else if (nest_c > 0) begin
        if (nest_c == 1) eng_done <= 1'b1;
        nest_c <= nest_c - 1;
      end else if (main_c > 0 && !eng_paused) begin
        if (main_c == 1) eng_done <= 1'b1;
        main_c <= main_c - 1;
      end
      if (eng_suspend) eng_paused <= 1'b1;
      if (eng_resume)  eng_paused <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (eng_start) begin
      n_start++; l_op = eng_op; l_addr = eng_addr; l_data = eng_data; l_mask = eng_blk_mask;
    end
    if (eng_suspend) n_susp++;
    if (eng_resume)  n_res++;
  end

  function automatic logic [11:0] A(int b, int k, int o);
    logic [31:0] bb = b, kk = k, oo = o;
    return {bb[0], kk[1:0], oo[8:0]};
  endfunction

  function automatic logic [1:0] mode_of(logic [7:0] c);
    case (c)
      8'h70: return 2'd1;
      8'h90: return 2'd2;
      8'h98: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] st_exp(bit rdy, bit es, bit ps, bit er);
    return {rdy, es, er, er, 1'b0, ps, 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!status[7] && n < 500) begin @(negedge clk); #1; n++; end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #1 check("R1 abort in reset", eng_abort, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 status", status, 8'h80);
    check("R1 modes", bank_mode, 0);
    check("R1 pulses", n_start + n_susp + n_res, 0);
    bm_exp[0] = 0; bm_exp[1] = 0;

    for (int i = 0; i < 40; i++) begin
      int b = $urandom % 2;
      logic [7:0] codes [4] = '{8'hFF, 8'h70, 8'h90, 8'h98};
      logic [7:0] c = codes[$urandom % 4];
      wr(A(b, $urandom % 4, $urandom % 512), {8'h00, c});
      bm_exp[b] = mode_of(c);
      check("R2 bank mode", bank_mode, {bm_exp[1], bm_exp[0]});
      rd_loc = {1'(b), 2'($urandom % 4)};
      #1 check("R12 rd_mode", rd_mode, bm_exp[b]);
    end
    wr(A(0,0,0), 16'h00FF); wr(A(1,0,0), 16'h00FF);

    wr(A(1,1,5), 16'h0040); wr(A(1,1,5), 16'h1234);
    check("R3 start", n_start, 1);
    check("R3 op", l_op, 1);
    check("R3 addr", l_addr, A(1,1,5));
    check("R3 data", l_data, 16'h1234);
    check("R3 bank status", bank_mode[3:2], 1);
    check("R7 busy", status, st_exp(0,0,0,0));
    wr(A(0,0,0), 16'h0040); wr(A(0,0,0), 16'h55AA); wr(A(0,0,0), 16'h00D0);
    check("R8 setup ignored", n_start, 1);
    wr(A(0,0,0), 16'h0090);
    check("R2 read cmd while busy", bank_mode[1:0], 2);
    wait_ready();
    check("R7 ready", status, 8'h80);
    check("R3 stays status", bank_mode[3:2], 1);

    wr(A(0,2,0), 16'h0020); wr(A(0,2,0), 16'h0033);
    check("R5 bad confirm", status, 8'hB0);
    check("R5 no start", n_start, 1);
    wr(A(0,0,0), 16'h00FF);
    check("R5 sticky", status, 8'hB0);

    wr(A(0,2,0), 16'h0020); wr(A(0,2,0), 16'h00D0);
    check("R4 blk erase start", n_start, 2);
    check("R4 blk op", l_op, 2);
    check("R4 blk mask", l_mask, 4'b0100);
    wr(A(0,0,0), 16'h0050);
    check("R8 clear ignored", status, 8'h30);
    wr(A(1,0,0), 16'h00B0);
    check("R9 suspend pulse", n_susp, 1);
    wait_ready();
    check("R9 erase paused", status, st_exp(1,1,0,1));
    wr(A(0,0,0), 16'h00FF);
    rd_loc = 3'b010;
    #1 check("R12 hidden block", rd_mode, 1);
    rd_loc = 3'b001;
    #1 check("R12 other block", rd_mode, 0);
    wr(A(0,0,0), 16'h0050);
    check("R11 clear in erase suspend", status, st_exp(1,1,0,0));
    wr(A(1,3,1), 16'h0040); wr(A(1,3,1), 16'hBEEF);
    check("R11 nested start", n_start, 3);
    check("R11 nested op", l_op, 1);
    check("R11 nested busy", status, st_exp(0,1,0,0));
    wait_ready();
    check("R11 back to suspend", status, st_exp(1,1,0,0));
    wr(A(0,0,0), 16'h00D0);
    check("R10 resume pulse", n_res, 1);
    check("R10 running", status, 8'h00);
    wait_ready();
    check("R7 erase done", status, 8'h80);
    rd_loc = 3'b010;
    #1 check("R12 unhidden", rd_mode, 0);

    wr(A(0,1,2), 16'h0040); wr(A(0,1,2), 16'h0A0A);
    check("R3 second program", n_start, 4);
    wr(A(0,0,0), 16'h00B0);
    check("R9 prog suspend", n_susp, 2);
    wait_ready();
    check("R9 prog paused", status, st_exp(1,0,1,0));
    wr(A(1,0,0), 16'h0040); wr(A(1,0,0), 16'h1111);
    check("R10 program ignored", n_start, 4);
    wr(A(1,0,0), 16'h00D0);
    check("R10 resume prog", n_res, 2);
    wait_ready();
    check("R7 prog done", status, 8'h80);

    blk_prot = 8'b0101_0000;
    wr(A(1,0,0), 16'h0080); wr(A(1,0,0), 16'h00D0);
    check("R4 bank erase start", n_start, 5);
    check("R4 bank op", l_op, 3);
    check("R4 bank mask", l_mask, 4'b1010);
    wr(A(1,0,0), 16'h00B0);
    check("R9 bank erase no suspend", n_susp, 2);
    check("R9 still busy", status, 8'h00);
    wait_ready();

    blk_prot = 8'b1111_0000;
    wr(A(1,0,0), 16'h00FF);
    wr(A(1,0,0), 16'h0080); wr(A(1,0,0), 16'h00D0);
    check("R6 no start", n_start, 5);
    check("R6 no error", status, 8'h80);
    check("R6 status mode", bank_mode[3:2], 1);
    wr(A(1,0,0), 16'h0080); wr(A(1,0,0), 16'h00FF);
    check("R5 bank bad confirm", status, 8'hB0);
    wr(A(1,0,0), 16'h0050);
    check("R5 cleared", status, 8'h80);

    wr(A(0,3,0), 16'h0040); wr(A(0,3,0), 16'h7777);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; #1;
    check("R13 abort", eng_abort, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk); #1;
    check("R13 idle", status, 8'h80);
    check("R13 modes", bank_mode, 0);
    wr(A(0,0,0), 16'h0050);
    check("R13 no stale done", status, 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule